// File: doc/BRIEF.md
# NiCd/NiMH Charge-Phase Controller

This block runs one charge cycle of a nickel battery pack. It takes digital flags from external comparators and a slope detector, and drives two open-drain style outputs: a charge-control sink that blocks the charging current while it is asserted, and a status sink that lights an LED. A cycle opens with a qualification step. It then proceeds through fast charge, an optional top-off phase and an open-ended pulse-trickle phase. A power-down override can interrupt the cycle at any point.

Every duration is counted in ticks of a single time-base strobe. Parameters set the scaling, so a simulation can shrink minutes to a few hundred ticks. A three-level mode input chooses the safety-time limit, the termination hold-off, the trickle pulse width and whether top-off follows fast charge. An inhibit input pauses fast charge and top-off together with their timers, and the cycle continues from the same point when inhibit is released.

Top module: `chg_phase_ctrl`

## Requirements
- R1: During reset `cc_sink` is 1 and `led_sink` is 0. After reset the cycle qualifies immediately, with no start delay, so fast charge begins if every flag is clear.
- R2: Qualification enters fast charge only when `ov_flag`, `uv_flag`, `hot_flag` and `tco_flag` are all 0. Otherwise the block goes to pulse-trickle and stays there until a new cycle.
- R3: Fast charge ends when its safety timer expires. The limit is 80 minutes for `tmode`=2'b00 (low), 160 minutes (200 when `LONG_MID`=1) for 2'b01 (mid, and also for 2'b11), and 40 minutes for 2'b10 (high). A minute is `TICKS_PER_MIN` ticks.
- R4: `vterm_flag` is ignored for a hold-off window that starts at fast-charge entry. The window is 150 s for low, 300 s for mid and 75 s for high, where a second is `TICKS_PER_SEC` ticks. After the window, `vterm_flag` ends fast charge within two clock edges.
- R5: `ov_flag` or `tco_flag` ends fast charge or top-off at once, whether or not inhibit is high. The block then goes straight to pulse-trickle, and this holds in low mode as well.
- R6: Top-off follows a timer or slope ending of fast charge, but only in low mode. It holds `cc_sink` at 0 for `TOP_W` ticks out of every `PERIOD_TICKS` ticks. Its safety timer restarts from zero at entry, and it ends on timer expiry, `ov_flag` or `tco_flag`.
- R7: Pulse-trickle holds `cc_sink` at 0 for `TRK_W_LOW`, `TRK_W_MID` or `TRK_W_HIGH` ticks out of every `PERIOD_TICKS` ticks, chosen by mode. It has no time limit.
- R8: While `inhibit` is 1, the safety timer and the hold-off timer are frozen, and during fast charge or top-off `cc_sink` follows the trickle pattern. When inhibit returns to 0, the timers continue from their frozen counts.
- R9: `led_sink` is 1 only in fast charge. While `inhibit` is 1 it holds its last value, except in power-down.
- R10: While `pd_flag` is 1, both `cc_sink` and `led_sink` are 0 (released). When `pd_flag` returns to 0, the block pulse-trickles.
- R11: A falling edge of `ov_flag` outside power-down starts a new cycle. `cc_sink` stays 1 for `START_DLY` ticks, and then qualification runs as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| tick | input | 1 | One-clock time-base strobe |
| tmode | input | 2 | Mode: 00 low, 01 mid, 10 high, 11 as mid |
| ov_flag | input | 1 | Cell voltage above maximum-cell threshold |
| uv_flag | input | 1 | Cell voltage below low-battery threshold |
| hot_flag | input | 1 | Temperature beyond fast-charge start limit |
| tco_flag | input | 1 | Temperature beyond cutoff |
| pd_flag | input | 1 | Cell voltage above power-down threshold |
| vterm_flag | input | 1 | Voltage-slope termination detected |
| inhibit | input | 1 | Suspend fast charge and top-off |
| cc_sink | output | 1 | 1 = charge pin pulled low (current blocked), 0 = released |
| led_sink | output | 1 | 1 = status pin pulled low (LED lit), 0 = released |

## Verification
An input change is registered into the phase state at the next clock edge, and the outputs are registered from that state at the edge after it. Both outputs are therefore due two edges after the stimulus. The bench samples on the falling clock edge and reads results three or more clocks after it drives an input. Timer-limited outcomes (safety time, hold-off, start delay) are measured in observed ticks and accepted within two ticks of the limit. Pulse patterns are checked by counting released-charge clocks over whole modulation periods, so the result does not depend on phase alignment.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
// Shared types for the charge-phase controller.
package chg_pkg;

    // Phases of one charge cycle.
    typedef enum logic [2:0] {
        ST_CHECK   = 3'd0,   // start delay and qualification
        ST_FAST    = 3'd1,   // fast charge
        ST_TOP     = 3'd2,   // top-off
        ST_TRICKLE = 3'd3,   // pulse-trickle, no limit
        ST_PDOWN   = 3'd4    // power-down, outputs released
    } chg_state_e;

    // Three-level mode input encoding.
    typedef enum logic [1:0] {
        TM_LOW  = 2'b00,
        TM_MID  = 2'b01,
        TM_HIGH = 2'b10,
        TM_RSVD = 2'b11
    } tmode_e;

endpackage

// File: rtl/chg_mode_decode.sv
`timescale 1ns/1ps
// Decodes the mode input into the per-mode limits: safety time and hold-off
// in ticks, trickle pulse width, and whether top-off is enabled.
// Assumes tmode is static during a cycle; code 11 behaves as mid.
module chg_mode_decode
    import chg_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60000,
    parameter int TICKS_PER_SEC = 1000,
    parameter int LONG_MID      = 0,
    parameter int TRK_W_LOW     = 37,
    parameter int TRK_W_MID     = 73,
    parameter int TRK_W_HIGH    = 18,
    parameter int TW            = 24,
    parameter int WW            = 11
) (
    input  logic [1:0]    tmode,
    output logic [TW-1:0] safe_lim,
    output logic [TW-1:0] hold_lim,
    output logic [WW-1:0] trk_w,
    output logic          top_en
);

    logic [TW-1:0] mid_safe;

    // The variant parameter selects the mid-mode safety limit.
    if (LONG_MID != 0) begin : g_long_mid
        assign mid_safe = TW'(200 * TICKS_PER_MIN);
    end else begin : g_short_mid
        assign mid_safe = TW'(160 * TICKS_PER_MIN);
    end

    // Select the limits for the current mode.
    always_comb begin
        case (tmode_e'(tmode))
            TM_LOW: begin
                safe_lim = TW'(80 * TICKS_PER_MIN);
                hold_lim = TW'(150 * TICKS_PER_SEC);
                trk_w    = WW'(TRK_W_LOW);
                top_en   = 1'b1;
            end
            TM_HIGH: begin
                safe_lim = TW'(40 * TICKS_PER_MIN);
                hold_lim = TW'(75 * TICKS_PER_SEC);
                trk_w    = WW'(TRK_W_HIGH);
                top_en   = 1'b0;
            end
            default: begin
                safe_lim = mid_safe;
                hold_lim = TW'(300 * TICKS_PER_SEC);
                trk_w    = WW'(TRK_W_MID);
                top_en   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/chg_tick_timer.sv
`timescale 1ns/1ps
// Tick-driven up-counter that saturates at a run-time limit.
// done is high once the count has reached the limit. clr takes priority
// over counting; en is expected to be a qualified one-clock tick.
module chg_tick_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    // Count qualified ticks up to the limit; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/chg_pulse_gen.sv
`timescale 1ns/1ps
// Modulation phase counter for the top-off and trickle patterns.
// The phase advances once per tick and wraps after PERIOD_TICKS ticks. It
// restarts at zero on clr (any phase change), so every pattern begins with
// its on-window.
module chg_pulse_gen #(
    parameter int PERIOD_TICKS = 1170,
    parameter int TOP_W        = 73,
    parameter int WW           = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [WW-1:0] trk_w,
    output logic          trk_on,
    output logic          top_on
);

    localparam logic [WW-1:0] LAST_PH = WW'(PERIOD_TICKS - 1);
    localparam logic [WW-1:0] TOP_WV  = WW'(TOP_W);

    logic [WW-1:0] phase_q;

    // Advance and wrap the modulation phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
        end
    end

    assign trk_on = (phase_q < trk_w);
    assign top_on = (phase_q < TOP_WV);

endmodule

// File: rtl/chg_phase_ctrl.sv
`timescale 1ns/1ps
// Charge-phase controller top.
// Sequences qualification, fast charge, optional top-off and pulse-trickle,
// and applies the power-down override. It owns the safety, hold-off and
// start-delay timers and modulates the charge sink. All inputs are assumed
// synchronous to clk; tick is a one-clock strobe. The outputs are registered
// from the current phase, so they follow a phase change by one clock.
module chg_phase_ctrl
    import chg_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60000,
    parameter int TICKS_PER_SEC = 1000,
    parameter int LONG_MID      = 0,
    parameter int PERIOD_TICKS  = 1170,
    parameter int TRK_W_LOW     = 37,
    parameter int TRK_W_MID     = 73,
    parameter int TRK_W_HIGH    = 18,
    parameter int TOP_W         = 73,
    parameter int START_DLY     = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] tmode,
    input  logic       ov_flag,
    input  logic       uv_flag,
    input  logic       hot_flag,
    input  logic       tco_flag,
    input  logic       pd_flag,
    input  logic       vterm_flag,
    input  logic       inhibit,
    output logic       cc_sink,
    output logic       led_sink
);

    localparam int TW = $clog2(200 * TICKS_PER_MIN + 300 * TICKS_PER_SEC + START_DLY + 2);
    localparam int WW = $clog2(PERIOD_TICKS + 1);

    chg_state_e    state_q, nxt;
    logic          ov_q;
    logic          rein_seen_q;
    logic          reinsert;
    logic          start_ok;
    logic          phase_chg;
    logic          in_fast, in_top;
    logic [TW-1:0] safe_lim, hold_lim, dly_lim;
    logic [WW-1:0] trk_w;
    logic          top_en;
    logic          safe_done, hold_done, dly_done;
    logic          trk_on, top_on;
    logic          cc_nx, led_nx;

    // Per-mode limits.
    chg_mode_decode #(
        .TICKS_PER_MIN (TICKS_PER_MIN),
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .LONG_MID      (LONG_MID),
        .TRK_W_LOW     (TRK_W_LOW),
        .TRK_W_MID     (TRK_W_MID),
        .TRK_W_HIGH    (TRK_W_HIGH),
        .TW            (TW),
        .WW            (WW)
    ) mode_i (
        .tmode    (tmode),
        .safe_lim (safe_lim),
        .hold_lim (hold_lim),
        .trk_w    (trk_w),
        .top_en   (top_en)
    );

    assign in_fast   = (state_q == ST_FAST);
    assign in_top    = (state_q == ST_TOP);
    assign phase_chg = (state_q != nxt);
    assign reinsert  = ov_q && !ov_flag && !pd_flag;
    assign start_ok  = !ov_flag && !uv_flag && !hot_flag && !tco_flag;
    assign dly_lim   = rein_seen_q ? TW'(START_DLY) : '0;

    // Safety timer: runs in fast charge and top-off, frozen by inhibit,
    // and restarted at every phase change.
    chg_tick_timer #(.TW(TW)) safe_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_chg),
        .en    (tick && !inhibit && (in_fast || in_top)),
        .limit (safe_lim),
        .done  (safe_done)
    );

    // Hold-off timer: runs in fast charge only, frozen by inhibit.
    chg_tick_timer #(.TW(TW)) hold_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_chg),
        .en    (tick && !inhibit && in_fast),
        .limit (hold_lim),
        .done  (hold_done)
    );

    // Start-delay timer: restarts on reinsertion and counts during qualification.
    chg_tick_timer #(.TW(TW)) dly_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reinsert),
        .en    (tick && (state_q == ST_CHECK)),
        .limit (dly_lim),
        .done  (dly_done)
    );

    // Modulation patterns for top-off and trickle.
    chg_pulse_gen #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .TOP_W        (TOP_W),
        .WW           (WW)
    ) pulse_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (phase_chg),
        .tick   (tick),
        .trk_w  (trk_w),
        .trk_on (trk_on),
        .top_on (top_on)
    );

    // Remember the last over-voltage level to detect reinsertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
        end else begin
            ov_q <= ov_flag;
        end
    end

    // Note that a reinsertion occurred; power-up alone skips the start delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rein_seen_q <= 1'b0;
        end else if (reinsert) begin
            rein_seen_q <= 1'b1;
        end
    end

    // Next-phase decision with power-down and reinsertion overrides.
    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_CHECK: begin
                if (dly_done) begin
                    nxt = start_ok ? ST_FAST : ST_TRICKLE;
                end
            end
            ST_FAST: begin
                if (ov_flag || tco_flag) begin
                    nxt = ST_TRICKLE;
                end else if (!inhibit && (safe_done || (vterm_flag && hold_done))) begin
                    nxt = top_en ? ST_TOP : ST_TRICKLE;
                end
            end
            ST_TOP: begin
                if (ov_flag || tco_flag || (!inhibit && safe_done)) begin
                    nxt = ST_TRICKLE;
                end
            end
            ST_TRICKLE: begin
                nxt = ST_TRICKLE;
            end
            ST_PDOWN: begin
                if (!pd_flag) begin
                    nxt = ST_TRICKLE;
                end
            end
            default: begin
                nxt = ST_TRICKLE;
            end
        endcase
        if (reinsert) begin
            nxt = ST_CHECK;
        end
        if (pd_flag) begin
            nxt = ST_PDOWN;
        end
    end

    // Phase register; power-up starts in qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CHECK;
        end else begin
            state_q <= nxt;
        end
    end

    // Output values for the current phase.
    always_comb begin
        case (state_q)
            ST_PDOWN:   cc_nx = 1'b0;
            ST_CHECK:   cc_nx = 1'b1;
            ST_FAST:    cc_nx = inhibit ? !trk_on : 1'b0;
            ST_TOP:     cc_nx = inhibit ? !trk_on : !top_on;
            default:    cc_nx = !trk_on;
        endcase
        if (state_q == ST_PDOWN) begin
            led_nx = 1'b0;
        end else if (inhibit) begin
            led_nx = led_sink;
        end else begin
            led_nx = in_fast;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_sink  <= 1'b1;
            led_sink <= 1'b0;
        end else begin
            cc_sink  <= cc_nx;
            led_sink <= led_nx;
        end
    end

endmodule

// File: rtl/chg_phase_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker for the charge-phase controller, bound to the top.
// It observes ports and the phase register and drives nothing.
module chg_phase_ctrl_chk
    import chg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] tmode,
    input logic       ov_flag,
    input logic       pd_flag,
    input logic       inhibit,
    input chg_state_e state_q,
    input logic       safe_done,
    input logic       cc_sink,
    input logic       led_sink
);

    // R10: a sustained power-down releases both outputs.
    a_r10_pd_release: assert property (@(posedge clk) disable iff (!rst_n)
        pd_flag && $past(pd_flag) && $past(rst_n) |=> (!cc_sink && !led_sink));

    // R10: leaving power-down always lands in trickle.
    a_r10_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_PDOWN) && (state_q != ST_PDOWN) && !pd_flag
        |-> (state_q == ST_TRICKLE));

    // R9: the status LED only turns on from fast charge.
    a_r9_led_from_fast: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_sink) |-> ($past(state_q) == ST_FAST));

    // R5: over-voltage ends fast charge in the next cycle, into trickle.
    a_r5_ov_stops_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAST) && ov_flag && !pd_flag |=> (state_q == ST_TRICKLE));

    // R6: top-off is entered only from fast charge in low mode.
    a_r6_top_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TOP) |->
        (($past(state_q) == ST_TOP) ||
         (($past(state_q) == ST_FAST) && ($past(tmode) == 2'b00))));

    // R8: inhibit freezes the safety-timer verdict during fast charge.
    a_r8_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit) && ($past(state_q) == ST_FAST) && (state_q == ST_FAST)
        && $stable(tmode) |-> $stable(safe_done));

endmodule

bind chg_phase_ctrl chg_phase_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmode     (tmode),
    .ov_flag   (ov_flag),
    .pd_flag   (pd_flag),
    .inhibit   (inhibit),
    .state_q   (state_q),
    .safe_done (safe_done),
    .cc_sink   (cc_sink),
    .led_sink  (led_sink)
);

// File: tb/chg_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for the charge-phase controller (compressed time base).
module chg_phase_ctrl_tb_top;

    localparam int TK  = 4;    // clocks per tick
    localparam int PER = 20;   // ticks per modulation period
    localparam int TPM = 10;   // ticks per minute
    localparam int TPS = 1;    // ticks per second
    localparam int DLY = 8;    // start delay in ticks
    localparam int WL = 4, WM = 6, WH = 2, WT = 5;

    typedef struct packed {
        logic [1:0]  tm;
        logic        vt;
        logic [15:0] ticks;
        logic [7:0]  w1;
        logic [7:0]  w2;
    } vec_t;

    // mode, slope flag held, expected fast length (ticks), first and later widths
    localparam vec_t VEC [6] = '{
        '{2'b01, 1'b0, 16'd1600, 8'd6, 8'd6},
        '{2'b00, 1'b0, 16'd800,  8'd5, 8'd4},
        '{2'b10, 1'b0, 16'd400,  8'd2, 8'd2},
        '{2'b01, 1'b1, 16'd300,  8'd6, 8'd6},
        '{2'b00, 1'b1, 16'd150,  8'd5, 8'd4},
        '{2'b10, 1'b1, 16'd75,   8'd2, 8'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [1:0] tm = 2'b01;
    logic ov = 1'b0, uv = 1'b0, hot = 1'b0, tco = 1'b0, pd = 1'b0;
    logic vterm = 1'b0, inh = 1'b0;
    logic cc_sink, led_sink;
    int vectors = 0, fails = 0, cyc = 0, tdiv = 0;

    chg_phase_ctrl #(
        .TICKS_PER_MIN (TPM), .TICKS_PER_SEC (TPS), .LONG_MID (0),
        .PERIOD_TICKS (PER), .TRK_W_LOW (WL), .TRK_W_MID (WM),
        .TRK_W_HIGH (WH), .TOP_W (WT), .START_DLY (DLY)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .tick (tick), .tmode (tm),
        .ov_flag (ov), .uv_flag (uv), .hot_flag (hot), .tco_flag (tco),
        .pd_flag (pd), .vterm_flag (vterm), .inhibit (inh),
        .cc_sink (cc_sink), .led_sink (led_sink)
    );

    always #2.5 clk = ~clk;

    // Time-base strobe, one clock in every TK.
    always @(posedge clk) begin
        if (tdiv == TK - 1) begin
            tdiv <= 0;
            tick <= 1'b1;
        end else begin
            tdiv <= tdiv + 1;
            tick <= 1'b0;
        end
    end

    // Watchdog.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc == 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        vectors++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tick) k++;
        end
    endtask

    // Power-up with the given mode and flags.
    task automatic start(input logic [1:0] m, input logic vt, input logic u,
                         input logic h, input logic t);
        @(negedge clk);
        rst_n = 1'b0;
        tm = m; vterm = vt; uv = u; hot = h; tco = t;
        ov = 1'b0; pd = 1'b0; inh = 1'b0;
        clks(4);
        rst_n = 1'b1;
    endtask

    // Ticks observed while the LED is lit.
    task automatic fast_len(output int n);
        int g = 0;
        n = 0;
        while (!led_sink && g < 8) begin
            @(negedge clk);
            g++;
        end
        while (led_sink && n < 6000) begin
            @(negedge clk);
            if (tick) n++;
        end
    endtask

    // Clocks with the charge pin released over whole periods.
    task automatic duty(input int per, output int on);
        on = 0;
        repeat (per * PER * TK) begin
            @(negedge clk);
            if (!cc_sink) on++;
        end
    endtask

    initial begin
        int n, on;
        string tag;

        // R1: reset state, then immediate fast charge after power-up.
        rst_n = 1'b0;
        clks(3);
        chk("R1 reset cc_sink", cc_sink, 1);
        chk("R1 reset led_sink", led_sink, 0);
        rst_n = 1'b1;
        clks(3);
        chk("R1 power-up fast led", led_sink, 1);
        chk("R1 power-up fast cc", cc_sink, 0);

        // Table walk: safety limits (R3), hold-off (R4), top-off (R6), trickle (R7).
        for (int i = 0; i < 6; i++) begin
            start(VEC[i].tm, VEC[i].vt, 1'b0, 1'b0, 1'b0);
            fast_len(n);
            tag = VEC[i].vt ? "R4 hold-off length" : "R3 safety length";
            chk_rng(tag, n, int'(VEC[i].ticks) - 2, int'(VEC[i].ticks) + 2);
            clks(4);
            duty(2, on);
            tag = (VEC[i].tm == 2'b00) ? "R6 top-off duty" : "R7 trickle duty";
            chk(tag, on, 2 * int'(VEC[i].w1) * TK);
            ticks(900);
            duty(2, on);
            chk("R7 late trickle duty", on, 2 * int'(VEC[i].w2) * TK);
        end

        // R2: start blocked by under-voltage, heat, cutoff.
        start(2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
        clks(4);
        chk("R2 uv blocks fast", led_sink, 0);
        duty(2, on);
        chk("R2 uv trickle duty", on, 2 * WM * TK);
        start(2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
        clks(4);
        chk("R2 hot blocks fast", led_sink, 0);
        start(2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
        clks(4);
        chk("R2 tco blocks fast", led_sink, 0);

        // R5: over-voltage in low mode goes to trickle, not top-off.
        start(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(20);
        ov = 1'b1;
        clks(3);
        chk("R5 ov ends fast", led_sink, 0);
        clks(4);
        duty(2, on);
        chk("R5 ov then trickle duty", on, 2 * WL * TK);

        // R11: reinsertion waits DLY ticks with charge blocked.
        ov = 1'b0;
        ticks(DLY - 2);
        chk("R11 pending led", led_sink, 0);
        chk("R11 pending cc", cc_sink, 1);
        ticks(4);
        clks(3);
        chk("R11 fast after delay", led_sink, 1);

        // R5: temperature cutoff ends fast charge.
        tco = 1'b1;
        clks(3);
        chk("R5 tco ends fast", led_sink, 0);
        tco = 1'b0;

        // R4: slope flag inside hold-off ignored, after it honoured.
        start(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(40);
        vterm = 1'b1;
        ticks(2);
        vterm = 1'b0;
        clks(3);
        chk("R4 slope ignored in hold-off", led_sink, 1);
        ticks(50);
        vterm = 1'b1;
        clks(3);
        chk("R4 slope ends fast after hold-off", led_sink, 0);

        // R8: inhibit freezes the timer, trickles, then resumes.
        start(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        clks(3);
        ticks(100);
        inh = 1'b1;
        clks(3);
        chk("R9 led frozen on under inhibit", led_sink, 1);
        duty(2, on);
        chk("R8 trickle during inhibit", on, 2 * WM * TK);
        ticks(160);
        inh = 1'b0;
        fast_len(n);
        chk_rng("R8 remaining fast after resume", n, 1497, 1503);

        // R9: LED held through an over-voltage ending under inhibit.
        start(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        clks(3);
        inh = 1'b1;
        ov = 1'b1;
        clks(4);
        chk("R9 led frozen after ov", led_sink, 1);
        inh = 1'b0;
        clks(3);
        chk("R9 led released after inhibit", led_sink, 0);

        // R10: power-down releases both outputs, exit trickles.
        start(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(10);
        ov = 1'b1;
        pd = 1'b1;
        clks(3);
        chk("R10 pd cc released", cc_sink, 0);
        chk("R10 pd led released", led_sink, 0);
        duty(1, on);
        chk("R10 pd cc released whole period", on, PER * TK);
        pd = 1'b0;
        clks(4);
        duty(2, on);
        chk("R10 exit trickle duty", on, 2 * WM * TK);
        chk("R10 exit led", led_sink, 0);
        ov = 1'b0;
        ticks(DLY + 4);
        clks(3);
        chk("R11 new cycle after pd", led_sink, 1);

        // R6: top-off ended by over-voltage.
        start(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        fast_len(n);
        clks(4);
        ov = 1'b1;
        clks(4);
        duty(2, on);
        chk("R6 top-off ended by ov", on, 2 * WL * TK);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule